// File: doc/BRIEF.md
# Transmit Byte Queue with Empty-Interrupt Holdoff

This block buffers bytes written by a CPU on their way to a serial transmit shift register. It holds up to sixteen bytes in first-in, first-out order. It raises a level interrupt request whenever the queue is empty and the transmit interrupt is enabled. The shift-register side takes the oldest byte as soon as one is present, so the CPU needs to issue no start command.

The interrupt has one special case, which covers a CPU that writes a single byte and then writes again a little later. A byte written into an empty queue drops the request at once. If that byte drains before a second byte arrives, the request stays low for a set number of character-time ticks. The ticks come from the baud logic, one per transmitted frame. The holdoff is cancelled as soon as two bytes have been in the queue together. From then on an empty queue raises the request on the next cycle.

Both data interfaces use valid/ready. On the CPU side, `wr_valid` is a single-cycle strobe that is never held. A strobe seen while `wr_ready` is low is discarded, not retried, and it sets a sticky overflow flag. On the shift side, `sh_valid` stays high while any byte is queued. `sh_data` holds steady until a cycle with `sh_ready` high consumes it. Flush, interrupt enable, overflow clear and the character tick are plain level or pulse inputs.

Top module: `tx_holdoff_fifo`

## Requirements
- R1: Bytes leave on `sh_data` in the order they were accepted, and up to DEPTH (default 16) bytes can be held at once.
- R2: `wr_ready` is low while DEPTH bytes are held. A `wr_valid` strobe while `wr_ready` is low is discarded: the byte is never delivered and the queued contents are unchanged.
- R3: When a byte is taken from a full queue, `wr_ready` is high in the next cycle.
- R4: `sh_valid` is high in every cycle in which the queue holds a byte. While `sh_ready` is low, `sh_valid` and `sh_data` hold their values.
- R5: With `irq_en` low, `irq_empty` is low. With `irq_en` high and no holdoff running, `irq_empty` is high exactly when the queue is empty.
- R6: A byte accepted into an empty queue makes `irq_empty` low from the next cycle.
- R7: After a byte is accepted into an empty queue, `irq_empty` stays low until HOLD_TICKS `char_tick` pulses have been seen in later cycles. This holds even if the queue drains before then. `irq_empty` rises in the cycle after the last of those pulses if the queue is empty; if the queue is not yet empty, it rises on the cycle after the queue empties. A tick in the accepting cycle itself is not counted.
- R8: Once two or more bytes have been held together, the holdoff is cancelled, and `irq_empty` rises in the cycle after the queue becomes empty.
- R9: `ovf_flag` is set by a discarded strobe and stays set until a cycle with `ovf_clr` high and no new discard. A discard in the same cycle as `ovf_clr` leaves the flag set.
- R10: A cycle with `flush` high empties the queue and cancels any holdoff. In the next cycle, `sh_valid` is low, `wr_ready` is high, and `irq_empty` equals `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous queue clear, also cancels holdoff |
| wr_data | input | DATA_W | Byte from the CPU |
| wr_valid | input | 1 | Single-cycle write strobe |
| wr_ready | output | 1 | Queue can accept a byte |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky: a strobe was discarded while full |
| sh_data | output | DATA_W | Oldest queued byte |
| sh_valid | output | 1 | Queue holds at least one byte |
| sh_ready | input | 1 | Shift register takes the byte this cycle |
| char_tick | input | 1 | One pulse per transmitted character frame |
| irq_en | input | 1 | Transmit interrupt enable level |
| irq_empty | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest situation to reach from the ports is a lone byte that has already drained while the holdoff window is still open, with the window then closing after a varying number of idle cycles. The stimulus sweeps two things: how many ticks arrive while the byte is still held back by `sh_ready` low, and how many idle cycles separate the remaining ticks. From those counts it works out the cycle in which the request must rise. A full-queue pass reaches the cancelled-holdoff path by the same route, and it also forces a discarded strobe.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned TXQ_DEPTH_DEF  = 16;
  localparam int unsigned TXQ_DATA_W_DEF = 8;
  localparam int unsigned TXQ_HOLD_DEF   = 1;

  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_RUN  = 1'b1
  } hold_state_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [OCC_W-1:0]  occ,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign full      = (occ == OCC_W'(DEPTH));
  assign empty     = (occ == '0);
endmodule

// File: rtl/txq_holdoff.sv
module txq_holdoff
  import txq_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 1,
  localparam int unsigned TICK_W = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic start,
  input  logic pair_seen,
  input  logic char_tick,
  output logic hold_active
);
  hold_state_e       state;
  logic [TICK_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HOLD_IDLE;
      left  <= '0;
    end else if (flush) begin
      state <= HOLD_IDLE;
      left  <= '0;
    end else if (start) begin
      state <= HOLD_RUN;
      left  <= TICK_W'(HOLD_TICKS);
    end else if (state == HOLD_RUN) begin
      if (pair_seen) begin
        state <= HOLD_IDLE;
        left  <= '0;
      end else if (char_tick) begin
        if (left == TICK_W'(1)) state <= HOLD_IDLE;
        left <= left - TICK_W'(1);
      end
    end
  end

  assign hold_active = (state == HOLD_RUN);
endmodule

// File: rtl/tx_holdoff_fifo.sv
module tx_holdoff_fifo
  import txq_pkg::*;
#(
  parameter int unsigned DATA_W     = TXQ_DATA_W_DEF,
  parameter int unsigned DEPTH      = TXQ_DEPTH_DEF,
  parameter int unsigned HOLD_TICKS = TXQ_HOLD_DEF,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              ovf_clr,
  output logic              ovf_flag,
  output logic [DATA_W-1:0] sh_data,
  output logic              sh_valid,
  input  logic              sh_ready,
  input  logic              char_tick,
  input  logic              irq_en,
  output logic              irq_empty
);
  logic             full, empty, push, pop, hold_active, dropped;
  logic [OCC_W-1:0] occ;

  assign push    = wr_valid && !full && !flush;
  assign pop     = sh_ready && !empty && !flush;
  assign dropped = wr_valid && full;

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push), .push_data(wr_data), .pop(pop),
    .head_data(sh_data), .occ(occ), .full(full), .empty(empty)
  );

  txq_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .start(push && empty),
    .pair_seen(occ >= OCC_W'(2)),
    .char_tick(char_tick),
    .hold_active(hold_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (dropped) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign wr_ready  = !full;
  assign sh_valid  = !empty;
  assign irq_empty = irq_en && empty && !hold_active;
endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OCC_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              ovf_clr,
  input logic              ovf_flag,
  input logic [DATA_W-1:0] sh_data,
  input logic              sh_valid,
  input logic              sh_ready,
  input logic              irq_en,
  input logic              irq_empty,
  input logic [OCC_W-1:0]  occ,
  input logic              hold_active
);
  assert_drop_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ovf_flag);

  assert_ready_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && sh_valid && sh_ready) |=> wr_ready);

  assert_head_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && !sh_ready && !flush) |=> (sh_valid && $stable(sh_data)));

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_empty);

  assert_first_write_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !sh_valid && !flush) |=> !irq_empty);

  assert_pair_cancels_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= OCC_W'(2) && !flush) |=> !hold_active);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!sh_valid && wr_ready && !hold_active));
endmodule

bind tx_holdoff_fifo txq_checker #(.DATA_W(DATA_W), .OCC_W(OCC_W)) u_txq_checker (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .sh_data(sh_data), .sh_valid(sh_valid),
  .sh_ready(sh_ready), .irq_en(irq_en), .irq_empty(irq_empty), .occ(occ),
  .hold_active(hold_active)
);

// File: tb/test_tx_holdoff_fifo.sv
`timescale 1ns/1ps
module test_tx_holdoff_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int HOLD = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_valid = 1'b0, ovf_clr = 1'b0, sh_ready = 1'b0, char_tick = 1'b0, irq_en = 1'b1;
  logic wr_ready, ovf_flag, sh_valid, irq_empty;
  logic [DW-1:0] sh_data;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tx_holdoff_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .HOLD_TICKS(HOLD)) i_tx_holdoff_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .sh_data(sh_data),
    .sh_valid(sh_valid), .sh_ready(sh_ready), .char_tick(char_tick), .irq_en(irq_en),
    .irq_empty(irq_empty)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 11);
  endfunction

  task automatic write_byte(input logic [DW-1:0] d);
    wr_data = d; wr_valid = 1'b1; step(); wr_valid = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1; step(); char_tick = 1'b0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      miscompares++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();
    chk("R5 reset irq", irq_empty, 1);
    chk("R4 reset sh_valid", sh_valid, 0);
    chk("R2 reset wr_ready", wr_ready, 1);
    chk("R9 reset ovf", ovf_flag, 0);

    // R5: enable gating
    irq_en = 1'b0; step();
    chk("R5 disabled", irq_empty, 0);
    irq_en = 1'b1; step();
    chk("R5 enabled empty", irq_empty, 1);

    // R1/R2/R3/R8: fill to full, overflow, then drain
    sh_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 ready before full", wr_ready, 1);
      write_byte(pat(i));
      chk("R4 valid while queued", sh_valid, 1);
      chk("R6 irq low while queued", irq_empty, 0);
    end
    chk("R2 not ready when full", wr_ready, 0);
    write_byte(8'hEE);
    chk("R2 overflow flag", ovf_flag, 1);
    chk("R4 head steady", sh_data, pat(0));
    sh_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R1 order", sh_data, pat(i));
      step();
      if (i == 0) chk("R3 ready after take", wr_ready, 1);
    end
    sh_ready = 1'b0;
    chk("R2 dropped byte absent", sh_valid, 0);
    chk("R8 irq right after drain", irq_empty, 1);

    // R9: sticky flag, same-cycle set beats clear
    step();
    chk("R9 flag held", ovf_flag, 1);
    for (int i = 0; i < DEPTH; i++) write_byte(pat(i));
    wr_valid = 1'b1; ovf_clr = 1'b1; step(); wr_valid = 1'b0;
    chk("R9 set wins", ovf_flag, 1);
    step(); ovf_clr = 1'b0;
    chk("R9 cleared", ovf_flag, 0);
    step();
    chk("R9 stays clear", ovf_flag, 0);

    // R10: flush full queue
    flush = 1'b1; step(); flush = 1'b0;
    chk("R10 empty", sh_valid, 0);
    chk("R10 ready", wr_ready, 1);
    chk("R10 irq", irq_empty, 1);

    // R8: two queued together, no holdoff
    write_byte(8'h5A); write_byte(8'hA5);
    sh_ready = 1'b1; step();
    chk("R8 irq low one left", irq_empty, 0);
    step(); sh_ready = 1'b0;
    chk("R8 irq without ticks", irq_empty, 1);

    // R6/R7 sweep: k ticks while byte held, gap g between remaining ticks
    for (int k = 0; k <= HOLD + 1; k++) begin
      for (int g = 0; g <= 2; g++) begin
        int seen;
        logic [DW-1:0] d;
        d = pat(k * 3 + g);
        sh_ready = 1'b0;
        char_tick = 1'b1;
        write_byte(d);
        char_tick = 1'b0;
        chk("R6 irq drops", irq_empty, 0);
        seen = 0;
        for (int t = 0; t < k; t++) begin
          tick(); seen++;
          chk("R4 data held", sh_data, d);
        end
        sh_ready = 1'b1; step(); sh_ready = 1'b0;
        chk("R7 irq after drain", irq_empty, (seen >= HOLD) ? 1 : 0);
        while (seen < HOLD) begin
          for (int w = 0; w < g; w++) begin
            step();
            chk("R7 irq low in window", irq_empty, 0);
          end
          tick(); seen++;
          chk("R7 irq at tick", irq_empty, (seen >= HOLD) ? 1 : 0);
        end
      end
    end

    // R10: flush cancels holdoff
    write_byte(8'h33);
    sh_ready = 1'b1; step(); sh_ready = 1'b0;
    chk("R7 held before flush", irq_empty, 0);
    flush = 1'b1; step(); flush = 1'b0;
    chk("R10 holdoff cancelled", irq_empty, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule